// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing half of a 2048-byte serial EEPROM. It runs on a fast system clock. It oversamples the two-wire clock and data lines and picks out START, repeated START and STOP conditions. It shifts bytes in and out most-significant bit first and acknowledges the bytes it accepts by pulling the data line low.

An 11-bit address pointer selects the memory location. The upper three bits of the pointer travel inside the device select byte and the lower eight come from a separate address byte, so a single address byte reaches all 2048 locations. The engine supports current-address reads, random reads through a repeated START, and sequential reads that step the pointer by one for every byte.

Each written byte goes to an external write buffer as a one-cycle strobe carrying the address and the data. Read data comes combinationally from a plain memory port addressed by the pointer. Two inputs keep the engine off the bus: a power-on-reset flag, and a busy flag raised by the self-timed programming cycle. While busy is high, a device select is not acknowledged, which lets a master poll for the end of the write.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A device select byte is acknowledged only when its upper nibble (bits 7..4) is 1010. Any other code gets no acknowledge, and the bytes that follow are ignored until the next START.
- R2: For an accepted device select, address byte or write data byte, the engine holds SDA low for the whole of the ninth clock.
- R3: A device select with bit 0 (R/W) equal to 0 loads its bits 3..1 into pointer bits 10..8. The next byte loads pointer bits 7..0. Each complete data byte after that produces one `wr_stb` cycle, with `wr_addr` set to the pointer and `wr_data` set to the byte, and the pointer then advances by one.
- R4: A device select with R/W=1 returns the byte at the current pointer, MSB first, and ignores its bits 3..1.
- R5: A random read (a write-type select, an address byte, a repeated START and then a read-type select) returns the byte at the address that was just loaded.
- R6: When the master pulls SDA low in the ninth clock of a read byte, the engine sends the byte at the next address.
- R7: The pointer wraps from 7FFh to 000h, both on writes and on reads.
- R8: When the master leaves SDA high in the ninth clock of a read byte, the engine releases SDA and does not drive it again until a new START.
- R9: A STOP returns the engine to idle with SDA released. A data byte cut short by a STOP produces no strobe and leaves the pointer unchanged.
- R10: While `por_active` is high, the engine never drives SDA and never strobes a write. SDA is released on the cycle after `por_active` is seen.
- R11: While `wbusy` is high, a device select is not acknowledged and does not load the pointer.
- R12: The engine only starts pulling SDA low after a falling SCL edge, so the data line stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_active | input | 1 | Power-on reset in progress; the engine stays off the bus |
| wbusy | input | 1 | Self-timed programming cycle in progress |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain driver enable) |
| mem_addr | output | 11 | Address pointer, used as the memory read address |
| mem_rdata | input | 8 | Read data for `mem_addr`, combinational |
| wr_stb | output | 1 | One-cycle write strobe to the write buffer |
| wr_addr | output | 11 | Address of the strobed byte |
| wr_data | output | 8 | Data of the strobed byte |

## Verification
A wrong pointer shows up at the ports within one byte. It appears either as a wrong `wr_addr` on the next strobe or as a wrong byte shifted out on the next read. So every read in the bench is placed where a stale, non-incremented or non-wrapped pointer would return different data. A wrong state in the control sequence shows up within one bit time: a missing or extra acknowledge in the ninth clock, SDA being driven after a rejected select or a master NACK, or a strobe appearing after a STOP that cut a byte short. The bench watches SDA on every clock during the phases where the engine must stay silent, and it checks every strobe against a queue of expected writes.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       mack;
        logic       sda_oe;
        logic       wr_stb;
        logic [7:0] wr_data;
    } slv_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_lvl  = scl_pipe_q[STAGES-1];
    assign sda_lvl  = sda_pipe_q[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_prev_q;
    assign scl_fall = ~scl_lvl & scl_prev_q;
    assign start_ev = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic [AW-9:0] hi_val,
    input  logic          ld_lo,
    input  logic [7:0]    lo_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (ld_hi) ptr_d[AW-1:8] = hi_val;
        if (ld_lo) ptr_d[7:0]    = lo_val;
        if (inc)   ptr_d         = ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int unsigned AW          = 11,
    parameter logic [3:0]  DEV_CODE    = 4'b1010,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_active,
    input  logic          wbusy,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int unsigned BW = AW - 8;

    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic ld_hi, ld_lo, inc;
    logic [AW-1:0] ptr;

    slv_regs_t     r_d, r_q;
    logic [AW-1:0] wr_addr_d, wr_addr_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    eeprom_addr_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ld_hi(ld_hi), .hi_val(r_q.sh[BW:1]),
        .ld_lo(ld_lo), .lo_val(r_q.sh),
        .inc(inc), .ptr(ptr)
    );

    always_comb begin
        r_d        = r_q;
        wr_addr_d  = wr_addr_q;
        r_d.wr_stb = 1'b0;
        ld_hi      = 1'b0;
        ld_lo      = 1'b0;
        inc        = 1'b0;
        if (por_active) begin
            r_d.st     = ST_IDLE;
            r_d.sda_oe = 1'b0;
            r_d.cnt    = '0;
        end else if (start_ev) begin
            r_d.st     = ST_DEV;
            r_d.sda_oe = 1'b0;
            r_d.cnt    = '0;
        end else if (stop_ev) begin
            r_d.st     = ST_IDLE;
            r_d.sda_oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end
                    if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = '0;
                        if (r_q.st == ST_DEV) begin
                            if (r_q.sh[7:4] == DEV_CODE && !wbusy) begin
                                r_d.sda_oe = 1'b1;
                                r_d.rw     = r_q.sh[0];
                                r_d.st     = ST_DEV_ACK;
                                ld_hi      = ~r_q.sh[0];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_ADDR) begin
                            r_d.sda_oe = 1'b1;
                            r_d.st     = ST_ADDR_ACK;
                            ld_lo      = 1'b1;
                        end else begin
                            r_d.sda_oe  = 1'b1;
                            r_d.st      = ST_WDATA_ACK;
                            r_d.wr_stb  = 1'b1;
                            r_d.wr_data = r_q.sh;
                            wr_addr_d   = ptr;
                            inc         = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.st     = ST_RDATA;
                            r_d.sh     = mem_rdata;
                            r_d.sda_oe = ~mem_rdata[7];
                        end else begin
                            r_d.st     = ST_ADDR;
                            r_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        r_d.st     = ST_WDATA;
                        r_d.sda_oe = 1'b0;
                        r_d.cnt    = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.sda_oe = 1'b0;
                            r_d.st     = ST_RACK;
                            r_d.cnt    = '0;
                            inc        = 1'b1;
                        end else begin
                            r_d.sh     = {r_q.sh[6:0], 1'b0};
                            r_d.sda_oe = ~r_q.sh[6];
                            r_d.cnt    = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) r_d.mack = ~sda_lvl;
                    if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st     = ST_RDATA;
                            r_d.sh     = mem_rdata;
                            r_d.sda_oe = ~mem_rdata[7];
                            r_d.cnt    = '0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '{st: ST_IDLE, default: '0};
            wr_addr_q <= '0;
        end else begin
            r_q       <= r_d;
            wr_addr_q <= wr_addr_d;
        end
    end

    assign sda_oe   = r_q.sda_oe;
    assign wr_stb   = r_q.wr_stb;
    assign wr_data  = r_q.wr_data;
    assign wr_addr  = wr_addr_q;
    assign mem_addr = ptr;
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
    parameter int unsigned AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_active,
    input logic          scl_fall,
    input logic          stop_ev,
    input logic          sda_oe,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] mem_addr
);
    // R10
    por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> !sda_oe);

    // R10
    por_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> !wr_stb);

    // R12
    drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> mem_addr == AW'(wr_addr + 1'b1));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_active(por_active), .scl_fall(scl_fall),
    .stop_ev(stop_ev), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .mem_addr(mem_addr)
);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, por_active, wbusy, scl_m, sda_m;
    logic        sda_oe, wr_stb;
    logic [10:0] mem_addr, wr_addr;
    logic [7:0]  mem_rdata, wr_data;
    logic        sda_bus;

    logic [7:0]  arr [0:2047];
    logic [7:0]  mdl [0:2047];
    logic [18:0] exp_q [$];
    int          n_chk = 0, n_err = 0;
    bit          quiet = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = arr[mem_addr];

    eeprom_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .por_active(por_active), .wbusy(wbusy),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison: silent phases and the write handoff queue.
    always @(negedge clk) begin
        if (quiet && rst_n) check(!sda_oe, "R8 or R10 silent SDA", sda_oe, 0);
        if (wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 or R9 unexpected strobe", {wr_addr, wr_data}, 0);
            end else begin
                logic [18:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R3 strobe addr/data", {wr_addr, wr_data}, e);
            end
            arr[wr_addr] = wr_data;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b0; wclk(10);
        scl_m = 1'b0; wclk(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(5);
        scl_m = 1'b1; wclk(10);
        sda_m = 1'b1; wclk(10);
    endtask

    task automatic bit_cyc(input logic b, output logic r);
        logic early;
        sda_m = b; wclk(5);
        scl_m = 1'b1; wclk(1);
        early = sda_bus; wclk(8);
        r = sda_bus;
        check(early == r, "R12 SDA stable while SCL high", r, early);
        wclk(1);
        scl_m = 1'b0; wclk(5);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], r);
        bit_cyc(1'b1, r);
        check(r == !exp_ack, tag, r, !exp_ack);
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit m_ack, input string tag);
        logic r;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, r);
            got[i] = r;
        end
        bit_cyc(!m_ack, r);
        check(got == exp, tag, got, exp);
    endtask

    task automatic put(input logic [10:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        mdl[a] = d;
        send_byte(d, 1'b1, "R3 data ack");
    endtask

    task automatic send_bits(input logic [3:0] v);
        logic r;
        for (int i = 3; i >= 0; i--) bit_cyc(v[i], r);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            arr[i] = 8'(i * 37 + 5);
            mdl[i] = 8'(i * 37 + 5);
        end
        rst_n = 1'b0; por_active = 1'b0; wbusy = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        check(sda_oe == 1'b0, "R9 reset SDA released", sda_oe, 0);
        check(wr_stb == 1'b0, "R9 reset no strobe", wr_stb, 0);
        check(mem_addr == 11'h000, "R9 reset pointer", mem_addr, 0);

        // R10: commands ignored during power-on reset
        por_active = 1'b1; quiet = 1'b1;
        bus_start();
        send_byte(8'hA0, 1'b0, "R10 select ignored");
        send_byte(8'h12, 1'b0, "R10 byte ignored");
        bus_stop();
        quiet = 1'b0; por_active = 1'b0; wclk(5);

        // R2 / R3: write two bytes at 0x345
        bus_start();
        send_byte(8'hA6, 1'b1, "R2 select ack");
        send_byte(8'h45, 1'b1, "R2 address ack");
        put(11'h345, 8'h11);
        put(11'h346, 8'h22);
        bus_stop();
        check(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 0);

        // R3 read-back via random read
        bus_start();
        send_byte(8'hA6, 1'b1, "R5 select ack");
        send_byte(8'h45, 1'b1, "R5 address ack");
        bus_start();
        send_byte(8'hA1, 1'b1, "R5 read select ack");
        read_byte(mdl[11'h345], 1'b1, "R3 written byte read back");
        read_byte(mdl[11'h346], 1'b0, "R6 second written byte");
        bus_stop();

        // R4: current read ignores select bits 3..1, then R8 NACK
        bus_start();
        send_byte(8'hAB, 1'b1, "R4 read select ack");
        read_byte(mdl[11'h347], 1'b0, "R4 current address byte");
        quiet = 1'b1;
        send_byte(8'hFF, 1'b0, "R8 silent after NACK");
        bus_stop();
        quiet = 1'b0;

        // R5 / R6: random read then sequential
        bus_start();
        send_byte(8'hA4, 1'b1, "R5 select ack");
        send_byte(8'h10, 1'b1, "R5 address ack");
        bus_start();
        send_byte(8'hA1, 1'b1, "R5 read select ack");
        read_byte(mdl[11'h210], 1'b1, "R5 random byte");
        read_byte(mdl[11'h211], 1'b1, "R6 sequential byte 1");
        read_byte(mdl[11'h212], 1'b0, "R6 sequential byte 2");
        bus_stop();

        // R7: write wrap
        bus_start();
        send_byte(8'hAE, 1'b1, "R7 select ack");
        send_byte(8'hFE, 1'b1, "R7 address ack");
        put(11'h7FE, 8'h5A);
        put(11'h7FF, 8'hC3);
        bus_stop();
        bus_start();
        send_byte(8'hA1, 1'b1, "R7 read select ack");
        read_byte(mdl[11'h000], 1'b1, "R7 pointer wrapped after write");
        read_byte(mdl[11'h001], 1'b0, "R7 byte after wrap");
        bus_stop();

        // R7: read wrap
        bus_start();
        send_byte(8'hAE, 1'b1, "R7 select ack");
        send_byte(8'hFF, 1'b1, "R7 address ack");
        bus_start();
        send_byte(8'hA1, 1'b1, "R7 read select ack");
        read_byte(mdl[11'h7FF], 1'b1, "R7 last byte");
        read_byte(mdl[11'h000], 1'b0, "R7 read wrapped");
        bus_stop();

        // R1: wrong device code
        quiet = 1'b1;
        bus_start();
        send_byte(8'hB0, 1'b0, "R1 wrong code no ack");
        send_byte(8'h00, 1'b0, "R1 following byte ignored");
        bus_stop();
        bus_start();
        send_byte(8'h20, 1'b0, "R1 wrong code no ack");
        bus_stop();
        quiet = 1'b0;
        bus_start();
        send_byte(8'hA1, 1'b1, "R1 valid select ack");
        read_byte(mdl[11'h001], 1'b0, "R1 pointer untouched");
        bus_stop();

        // R11: busy write cycle
        wbusy = 1'b1; quiet = 1'b1;
        bus_start();
        send_byte(8'hAE, 1'b0, "R11 busy select no ack");
        send_byte(8'h00, 1'b0, "R11 byte ignored");
        bus_stop();
        quiet = 1'b0; wbusy = 1'b0;
        bus_start();
        send_byte(8'hA1, 1'b1, "R11 select ack after busy");
        read_byte(mdl[11'h002], 1'b0, "R11 pointer not loaded while busy");
        bus_stop();

        // R9: STOP inside a data byte
        bus_start();
        send_byte(8'hA0, 1'b1, "R9 select ack");
        send_byte(8'h20, 1'b1, "R9 address ack");
        send_bits(4'hA);
        bus_stop();
        wclk(2);
        check(sda_oe == 1'b0, "R9 SDA released after STOP", sda_oe, 0);
        check(exp_q.size() == 0, "R9 no strobe for partial byte", exp_q.size(), 0);
        bus_start();
        send_byte(8'hA1, 1'b1, "R9 read select ack");
        read_byte(mdl[11'h020], 1'b0, "R9 pointer unchanged");
        bus_stop();

        wclk(20);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule